// File: doc/BRIEF.md
# Safe Petri Net Marking Engine

A clocked controller that executes a safe Petri net in hardware. Each place holds at most one token and is stored as one register bit; the full set of bits is the marking, and each bit drives a level action directly. Each transition is described at elaboration time by four constant place masks (consumed places, produced places, places that must be marked without being consumed, and places that must be empty) plus one external firing-condition input, usually a sensor reading or a combination of them.

On every rising clock edge the engine evaluates all transitions against the current marking and their conditions, picks the set that fires, and in one update removes the tokens of their consumed places and deposits tokens in their produced places. A one-cycle pulse per transition reports each firing as an impulse action. When two enabled transitions would consume the same place in one cycle, the lower-numbered one fires and the other waits. A synchronous reset reloads the initial marking.

Top module: `petri_marking_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `marking` becomes the `INIT` parameter and `fired` becomes all zero.
- R2: A transition whose consumed places (bit p of `PRE[j*N +: N]` set means place p is consumed by transition j) are not all marked does not fire.
- R3: A place in a transition's read mask (`READ[j*N +: N]`) must be marked for the transition to fire, and firing leaves that place's token in place unless another firing transition consumes it.
- R4: A place in a transition's inhibit mask (`INHIB[j*N +: N]`) must be empty for the transition to fire, and firing does not mark it.
- R5: A transition fires only in a cycle in which its bit of `cond` is 1.
- R6: When transition j fires, the marking after that edge has every place of `POST[j*N +: N]` set and every consumed place cleared unless produced by a firing transition, with no intermediate marking.
- R7: `fired[j]` is high for exactly the cycle following the edge at which transition j fired, aligned with the updated marking.
- R8: Among enabled transitions with a true condition that share a consumed place, only the lowest-numbered one fires in that cycle.
- R9: Transitions that share no consumed place fire in the same cycle when each is enabled and conditioned.
- R10: When no transition fires, `marking` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the initial marking, active high |
| cond | input | M | Firing condition, one bit per transition |
| marking | output | N | Current token per place (level actions) |
| fired | output | M | One-cycle pulse per transition that fired at the last edge (impulse actions) |

## Verification
Assertions check on every cycle that a reported firing had its condition, its consumed and read places marked and its inhibit places empty one cycle earlier, that its produced places are now marked, that no two pulsed transitions share a consumed place, and that the marking holds when nothing fired. Only the bench scenarios show that priority picks the lower index, that a blocked read or inhibit arc actually withholds a firing, that a transition may read a place another one consumes in the same cycle, and that the exact marking after each step matches a behavioural model across a long stream of varied conditions.

// File: rtl/petri_marking_engine.sv
module petri_marking_engine #(
  parameter int N = 8,
  parameter int M = 8,
  parameter logic [M*N-1:0] PRE   = 64'h4080_2020_1804_0201,
  parameter logic [M*N-1:0] POST  = 64'h8040_0601_2010_0806,
  parameter logic [M*N-1:0] READ  = 64'h0000_0000_0000_8000,
  parameter logic [M*N-1:0] INHIB = 64'h0000_0000_0040_0000,
  parameter logic [N-1:0]   INIT  = 8'h81
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] cond,
  output logic [N-1:0] marking,
  output logic [M-1:0] fired
);

  logic [M-1:0] enabled;
  logic [M-1:0] fire;
  logic [N-1:0] take;
  logic [N-1:0] give;

  for (genvar j = 0; j < M; j++) begin : g_en
    localparam logic [N-1:0] P_IN  = PRE[j*N +: N];
    localparam logic [N-1:0] P_RD  = READ[j*N +: N];
    localparam logic [N-1:0] P_INH = INHIB[j*N +: N];
    assign enabled[j] = ((marking & P_IN) == P_IN) &&
                        ((marking & P_RD) == P_RD) &&
                        ((marking & P_INH) == '0);
  end

  always_comb begin
    take = '0;
    give = '0;
    fire = '0;
    for (int j = 0; j < M; j++) begin
      if (enabled[j] && cond[j] && ((take & PRE[j*N +: N]) == '0)) begin
        fire[j] = 1'b1;
        take    = take | PRE[j*N +: N];
        give    = give | POST[j*N +: N];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      marking <= INIT;
      fired   <= '0;
    end else begin
      marking <= (marking & ~take) | give;
      fired   <= fire;
    end
  end

  for (genvar j = 0; j < M; j++) begin : g_chk
    localparam logic [N-1:0] C_IN  = PRE[j*N +: N];
    localparam logic [N-1:0] C_OUT = POST[j*N +: N];
    localparam logic [N-1:0] C_RD  = READ[j*N +: N];
    localparam logic [N-1:0] C_INH = INHIB[j*N +: N];

    // R5
    cond_needed_chk: assert property (@(posedge clk) disable iff (rst)
      fired[j] |-> $past(cond[j]));
    // R2
    tokens_present_chk: assert property (@(posedge clk) disable iff (rst)
      fired[j] |-> (($past(marking) & C_IN) == C_IN));
    // R3
    read_marked_chk: assert property (@(posedge clk) disable iff (rst)
      fired[j] |-> (($past(marking) & C_RD) == C_RD));
    // R4
    inhib_empty_chk: assert property (@(posedge clk) disable iff (rst)
      fired[j] |-> (($past(marking) & C_INH) == '0));
    // R6
    outputs_set_chk: assert property (@(posedge clk) disable iff (rst)
      fired[j] |-> ((marking & C_OUT) == C_OUT));
  end

  for (genvar p = 0; p < N; p++) begin : g_place
    logic [M-1:0] users;
    for (genvar j = 0; j < M; j++) begin : g_u
      assign users[j] = PRE[j*N + p];
    end
    // R8
    single_consumer_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fired & users));
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fired == '0) |-> $stable(marking));

endmodule

// File: tb/test_petri_marking_engine.sv
module test_petri_marking_engine;
  localparam int N = 8;
  localparam int M = 8;
  localparam logic [M*N-1:0] PRE   = 64'h4080_2020_1804_0201;
  localparam logic [M*N-1:0] POST  = 64'h8040_0601_2010_0806;
  localparam logic [M*N-1:0] READ  = 64'h0000_0000_0000_8000;
  localparam logic [M*N-1:0] INHIB = 64'h0000_0000_0040_0000;
  localparam logic [N-1:0]   INIT  = 8'h81;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [M-1:0] cond = '0;
  logic [N-1:0] marking;
  logic [M-1:0] fired;

  int total = 0;
  int bad = 0;
  logic [N-1:0] ref_mark;
  logic [M-1:0] ref_fire;

  always #4 clk = ~clk;

  petri_marking_engine #(.N(N), .M(M), .PRE(PRE), .POST(POST), .READ(READ),
    .INHIB(INHIB), .INIT(INIT)) i_petri_marking_engine (
    .clk(clk), .rst(rst), .cond(cond), .marking(marking), .fired(fired));

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model: winners kept in a queue, each candidate checked against them
  task automatic model(input logic [M-1:0] c);
    int winners[$];
    logic [N-1:0] nxt;
    nxt = ref_mark;
    ref_fire = '0;
    for (int j = 0; j < M; j++) begin
      bit ok;
      ok = c[j];
      for (int p = 0; p < N; p++) begin
        if (PRE[j*N+p] && !ref_mark[p]) ok = 0;
        if (READ[j*N+p] && !ref_mark[p]) ok = 0;
        if (INHIB[j*N+p] && ref_mark[p]) ok = 0;
      end
      foreach (winners[w])
        for (int p = 0; p < N; p++)
          if (PRE[winners[w]*N+p] && PRE[j*N+p]) ok = 0;
      if (ok) winners.push_back(j);
    end
    foreach (winners[w]) begin
      ref_fire[winners[w]] = 1'b1;
      for (int p = 0; p < N; p++) if (PRE[winners[w]*N+p]) nxt[p] = 1'b0;
    end
    foreach (winners[w])
      for (int p = 0; p < N; p++) if (POST[winners[w]*N+p]) nxt[p] = 1'b1;
    ref_mark = nxt;
  endtask

  task automatic step(input logic [M-1:0] c, input logic [7:0] em, input logic [7:0] ef, input string tag);
    @(negedge clk);
    cond = c;
    model(c);
    @(posedge clk);
    #2;
    check(tag, "marking", marking, em);
    check(tag, "fired", fired, ef);
    check(tag, "model marking", marking, ref_mark);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cond = '0;
    @(posedge clk);
    @(posedge clk);
    #2;
    check("R1", "reset marking", marking, INIT);
    check("R1", "reset fired", fired, 8'h00);
    ref_mark = INIT;
    ref_fire = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    step(8'h00, 8'h81, 8'h00, "R5");   // t0 enabled but no condition
    step(8'h3E, 8'h81, 8'h00, "R2");   // t1..t5 lack input tokens
    step(8'h00, 8'h81, 8'h00, "R10");
    step(8'h01, 8'h86, 8'h01, "R6");   // fork: p0 -> p1,p2
    step(8'h00, 8'h86, 8'h00, "R7");   // pulse lasts one cycle
    step(8'h40, 8'h46, 8'h40, "R6");   // t6 moves p7 -> p6
    step(8'h06, 8'h46, 8'h00, "R3");   // t1 blocked (p7 empty), t2 blocked (p6 full)
    step(8'h06, 8'h46, 8'h00, "R4");
    step(8'h80, 8'h86, 8'h80, "R6");   // t7 restores p7
    step(8'h06, 8'h98, 8'h06, "R9");   // t1,t2 together, p7 kept
    step(8'h08, 8'hA0, 8'h08, "R6");   // join
    step(8'h30, 8'h81, 8'h10, "R8");   // t4 beats t5
    step(8'h01, 8'h86, 8'h01, "R6");
    step(8'h06, 8'h98, 8'h06, "R3");
    step(8'h08, 8'hA0, 8'h08, "R6");
    step(8'h20, 8'h86, 8'h20, "R8");   // t5 alone may fire
    step(8'h42, 8'h4C, 8'h42, "R3");   // t1 reads p7 while t6 consumes it
    step(8'h04, 8'h4C, 8'h00, "R4");   // t2 inhibited by p6
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [M-1:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = lfsr[7:0] & lfsr[15:8];
      @(negedge clk);
      cond = c;
      model(c);
      @(posedge clk);
      #2;
      check("R6", "marking vs model", marking, ref_mark);
      check("R7", "fired vs model", fired, ref_fire);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule